// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider Chain

This block holds the digital counting logic of an integer-N frequency synthesizer. On the feedback side, a prescaler divides the oscillator-rate clock by 24 or by 25. A main counter and a swallow counter choose the modulus for each prescaler period, so one feedback pulse is produced every 24·N + A oscillator cycles. On the reference side, a programmable counter divides the doubled reference by R. A phase/frequency detector compares the two divided pulse trains and produces up and down requests for an external charge pump. The resulting loop sets f_osc = (24·N + A)·(2·f_ref)/R.

The whole block runs on the oscillator-rate clock `clk`. Each rising edge of the doubled reference reaches the block as `ref_en`. This is a one-cycle strobe that has already been synchronised into `clk`. A one-cycle `cfg_load` stages a new N, A and R. Each counter adopts its staged values only when it reaches its own terminal count, so no divided period mixes old and new settings. Some settings are invalid: N < 3, R < 3, or A > N. While such a setting is active, the block holds every counter and the detector cleared and raises an error flag.

Top module: `dms_synth_div`

## Requirements
- R1: `fb_pulse` is high for exactly one clock. In steady state, consecutive rising edges of `fb_pulse` are exactly 24·N + A clocks apart. Each feedback cycle is made of A prescaler periods of 25 clocks followed by N−A periods of 24 clocks.
- R2: `ref_pulse` is high for exactly one clock. In steady state, it rises once for every R clocks on which `ref_en` was high. The pulse appears on the clock after the R-th such strobe.
- R3: A high `cfg_load` captures `cfg_n`, `cfg_a` and `cfg_r` into staging registers. The feedback counters adopt the staged N and A at the edge that ends their current cycle. The reference counter adopts the staged R at the edge that ends its current cycle. The period already in progress therefore completes with the old value.
- R4: A setting is invalid when the active N is below 3, the active R is below 3, or the active A exceeds the active N. While an invalid setting is active, `cfg_err` is 1 from the following clock on, and `fb_pulse`, `ref_pulse`, `pfd_up` and `pfd_dn` stay 0.
- R5: While an invalid setting is active, both dividers adopt the staged values on every clock. Loading a valid setting clears `cfg_err` and restarts both dividers from count zero.
- R6: A `ref_pulse` sets `pfd_up` and an `fb_pulse` sets `pfd_dn` on the next clock. When both would be set, both are cleared instead. `pfd_up` and `pfd_dn` are never high together.
- R7: Synchronous active-high reset drives every output to 0 and loads the default N, A and R as both staged and active values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One-cycle strobe per doubled-reference edge |
| cfg_load | input | 1 | Stage cfg_n, cfg_a, cfg_r |
| cfg_n | input | N_W (11) | Main-counter value N |
| cfg_a | input | A_W (5) | Swallow-counter value A |
| cfg_r | input | R_W (9) | Reference divide value R |
| fb_pulse | output | 1 | Divided feedback pulse |
| ref_pulse | output | 1 | Divided reference pulse |
| pfd_up | output | 1 | Detector up request (reference leads) |
| pfd_dn | output | 1 | Detector down request (feedback leads) |
| cfg_err | output | 1 | Active setting is invalid |

## Verification
The assertions assume that `ref_en` is a single-clock strobe that is already synchronous to `clk`. They also assume that `cfg_load` is sampled only together with stable configuration words. The bench drives every input on the falling edge and raises `ref_en` at random with a chosen density. It uses valid settings with small N, so that many feedback cycles fit in a run, including the corners A = 0, A = N, N = 3 and R = 3. Each of the three kinds of invalid setting is loaded on purpose, held, and then replaced by a valid one.

// File: rtl/dms_pkg.sv
package dms_pkg;
  localparam int PRE_M = 24;
  localparam int N_MIN = 3;
  localparam int R_MIN = 3;

  function automatic logic cfg_bad(input int unsigned n, input int unsigned a,
                                   input int unsigned r);
    return (n < N_MIN) || (r < R_MIN) || (a > n);
  endfunction
endpackage

// File: rtl/dms_prescaler.sv
module dms_prescaler #(
  parameter int M = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic mod_hi,
  output logic pre_tc
);
  localparam int PC_W = $clog2(M + 1);

  logic [PC_W-1:0] pc;

  assign pre_tc = mod_hi ? (pc == PC_W'(M)) : (pc == PC_W'(M - 1));

  always_ff @(posedge clk) begin
    if (rst || hold) pc <= '0;
    else if (pre_tc) pc <= '0;
    else             pc <= pc + 1'b1;
  end

  AST_PRE_LEN: assert property (@(posedge clk) disable iff (rst)
    pc <= PC_W'(M)); // R1
endmodule

// File: rtl/dms_fb_ctrl.sv
module dms_fb_ctrl #(
  parameter int N_W   = 11,
  parameter int A_W   = 5,
  parameter int DEF_N = 4,
  parameter int DEF_A = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold,
  input  logic           pre_tc,
  input  logic [N_W-1:0] stg_n,
  input  logic [A_W-1:0] stg_a,
  output logic           mod_hi,
  output logic           fb_pulse,
  output logic [N_W-1:0] n_act,
  output logic [A_W-1:0] a_act
);
  logic [N_W-1:0] pidx;
  logic           term;

  assign mod_hi = pidx < N_W'(a_act);
  assign term   = pre_tc && (pidx == n_act - N_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      n_act    <= N_W'(DEF_N);
      a_act    <= A_W'(DEF_A);
      pidx     <= '0;
      fb_pulse <= 1'b0;
    end else if (hold) begin
      n_act    <= stg_n;
      a_act    <= stg_a;
      pidx     <= '0;
      fb_pulse <= 1'b0;
    end else begin
      fb_pulse <= 1'b0;
      if (term) begin
        pidx     <= '0;
        fb_pulse <= 1'b1;
        n_act    <= stg_n;
        a_act    <= stg_a;
      end else if (pre_tc) begin
        pidx <= pidx + 1'b1;
      end
    end
  end

  AST_FB_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> !fb_pulse); // R1
  AST_FB_LOAD_AT_TC: assert property (@(posedge clk) disable iff (rst)
    !$stable(n_act) |-> $past(hold || term)); // R3
endmodule

// File: rtl/dms_ref_div.sv
module dms_ref_div #(
  parameter int R_W   = 9,
  parameter int DEF_R = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold,
  input  logic           ref_en,
  input  logic [R_W-1:0] stg_r,
  output logic           ref_pulse,
  output logic [R_W-1:0] r_act
);
  logic [R_W-1:0] rcnt;
  logic           term;

  assign term = ref_en && (rcnt == r_act - R_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      r_act     <= R_W'(DEF_R);
      rcnt      <= '0;
      ref_pulse <= 1'b0;
    end else if (hold) begin
      r_act     <= stg_r;
      rcnt      <= '0;
      ref_pulse <= 1'b0;
    end else begin
      ref_pulse <= term;
      if (term) begin
        rcnt  <= '0;
        r_act <= stg_r;
      end else if (ref_en) begin
        rcnt <= rcnt + 1'b1;
      end
    end
  end

  AST_REF_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    !hold |-> rcnt < r_act); // R2
  AST_REF_LOAD_AT_TC: assert property (@(posedge clk) disable iff (rst)
    !$stable(r_act) |-> $past(hold || term)); // R3
endmodule

// File: rtl/dms_pfd.sv
module dms_pfd (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic ref_pulse,
  input  logic fb_pulse,
  output logic up,
  output logic dn
);
  logic set_u, set_d;

  assign set_u = up || ref_pulse;
  assign set_d = dn || fb_pulse;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (set_u && set_d) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= set_u;
      dn <= set_d;
    end
  end

  AST_PFD_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(up && dn)); // R6
  AST_PFD_SET_UP: assert property (@(posedge clk) disable iff (rst)
    (ref_pulse && !fb_pulse && !dn && !hold) |=> up); // R6
endmodule

// File: rtl/dms_synth_div.sv
module dms_synth_div
  import dms_pkg::*;
#(
  parameter int N_W   = 11,
  parameter int A_W   = 5,
  parameter int R_W   = 9,
  parameter int DEF_N = 4,
  parameter int DEF_A = 1,
  parameter int DEF_R = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ref_en,
  input  logic           cfg_load,
  input  logic [N_W-1:0] cfg_n,
  input  logic [A_W-1:0] cfg_a,
  input  logic [R_W-1:0] cfg_r,
  output logic           fb_pulse,
  output logic           ref_pulse,
  output logic           pfd_up,
  output logic           pfd_dn,
  output logic           cfg_err
);
  logic [N_W-1:0] stg_n, n_act;
  logic [A_W-1:0] stg_a, a_act;
  logic [R_W-1:0] stg_r, r_act;
  logic           hold;
  logic           mod_hi;
  logic           pre_tc;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_n <= N_W'(DEF_N);
      stg_a <= A_W'(DEF_A);
      stg_r <= R_W'(DEF_R);
    end else if (cfg_load) begin
      stg_n <= cfg_n;
      stg_a <= cfg_a;
      stg_r <= cfg_r;
    end
  end

  assign hold = cfg_bad(32'(n_act), 32'(a_act), 32'(r_act));

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= hold;
  end

  dms_prescaler #(.M(PRE_M)) i_pre (
    .clk(clk), .rst(rst), .hold(hold), .mod_hi(mod_hi), .pre_tc(pre_tc)
  );

  dms_fb_ctrl #(.N_W(N_W), .A_W(A_W), .DEF_N(DEF_N), .DEF_A(DEF_A)) i_fb (
    .clk(clk), .rst(rst), .hold(hold), .pre_tc(pre_tc),
    .stg_n(stg_n), .stg_a(stg_a), .mod_hi(mod_hi),
    .fb_pulse(fb_pulse), .n_act(n_act), .a_act(a_act)
  );

  dms_ref_div #(.R_W(R_W), .DEF_R(DEF_R)) i_ref (
    .clk(clk), .rst(rst), .hold(hold), .ref_en(ref_en),
    .stg_r(stg_r), .ref_pulse(ref_pulse), .r_act(r_act)
  );

  dms_pfd i_pfd (
    .clk(clk), .rst(rst), .hold(hold),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .up(pfd_up), .dn(pfd_dn)
  );

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!fb_pulse && !ref_pulse && !pfd_up && !pfd_dn)); // R4
  AST_ERR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_err) |-> $past(hold)); // R4
endmodule

// File: tb/test_dms_synth_div.sv
module test_dms_synth_div;
  localparam int N_W = 11, A_W = 5, R_W = 9;
  localparam int DN = 4, DA = 1, DR = 4;

  logic clk = 1'b0, rst = 1'b1, ref_en = 1'b0, cfg_load = 1'b0;
  logic [N_W-1:0] cfg_n = '0;
  logic [A_W-1:0] cfg_a = '0;
  logic [R_W-1:0] cfg_r = '0;
  logic fb_pulse, ref_pulse, pfd_up, pfd_dn, cfg_err;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int stg_n = DN, stg_a = DA, stg_r = DR;
  int pend_n, pend_a, pend_r;
  bit pend = 1'b0;
  int fb_cur = 0, r_cur = 0, fb_cyc = 0, r_cnt = 0;
  bit fb_skip = 1'b1, r_skip = 1'b1;
  int fb_seen = 0, r_seen = 0;
  bit mu = 1'b0, md = 1'b0, pfd_on = 1'b1, pfd_sync = 1'b1;
  int ref_div = 2;
  bit req_load = 1'b0;
  int req_n, req_a, req_r;

  always #2.5 clk = ~clk;

  dms_synth_div #(.N_W(N_W), .A_W(A_W), .R_W(R_W),
                  .DEF_N(DN), .DEF_A(DA), .DEF_R(DR)) i_dms_synth_div (
    .clk(clk), .rst(rst), .ref_en(ref_en), .cfg_load(cfg_load),
    .cfg_n(cfg_n), .cfg_a(cfg_a), .cfg_r(cfg_r),
    .fb_pulse(fb_pulse), .ref_pulse(ref_pulse),
    .pfd_up(pfd_up), .pfd_dn(pfd_dn), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int fb_len(input int n, input int a);
    return 24 * n + a;
  endfunction

  task automatic run(input int ncyc);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      // feedback spacing (R1), old value finishes its period (R3)
      fb_cyc++;
      if (fb_pulse) begin
        fb_seen++;
        if (!fb_skip) chk(fb_cyc == fb_cur, "R1/R3 feedback spacing", fb_cyc, fb_cur);
        fb_skip = 1'b0;
        fb_cur  = fb_len(stg_n, stg_a);
        fb_cyc  = 0;
      end
      // reference spacing (R2), old value finishes its period (R3)
      if (ref_pulse) begin
        r_seen++;
        if (!r_skip) chk(r_cnt == r_cur, "R2/R3 reference strobes", r_cnt, r_cur);
        r_skip = 1'b0;
        r_cur  = stg_r;
        r_cnt  = 0;
      end
      // detector model (R6)
      if (pfd_up && pfd_dn) chk(1'b0, "R6 up and dn together", 1, 0);
      if (pfd_on) begin
        if (pfd_sync) begin
          mu = pfd_up; md = pfd_dn; pfd_sync = 1'b0;
        end else if (pfd_up !== mu || pfd_dn !== md) begin
          chk(1'b0, "R6 detector state", {30'd0, pfd_up, pfd_dn}, {30'd0, mu, md});
          mu = pfd_up; md = pfd_dn;
        end else if (fb_pulse || ref_pulse) begin
          chk(1'b1, "R6 detector state", 0, 0);
        end
        if ((mu || ref_pulse) && (md || fb_pulse)) begin
          mu = 1'b0; md = 1'b0;
        end else begin
          mu = mu || ref_pulse; md = md || fb_pulse;
        end
      end
      if (pend) begin
        stg_n = pend_n; stg_a = pend_a; stg_r = pend_r; pend = 1'b0;
      end
      ref_en = ($urandom % ref_div) == 0;
      if (ref_en) r_cnt++;
      if (req_load) begin
        cfg_load = 1'b1;
        cfg_n = N_W'(req_n); cfg_a = A_W'(req_a); cfg_r = R_W'(req_r);
        pend_n = req_n; pend_a = req_a; pend_r = req_r; pend = 1'b1;
        req_load = 1'b0;
      end else begin
        cfg_load = 1'b0;
      end
    end
  endtask

  task automatic load_run(input int n, input int a, input int r, input int ncyc);
    req_load = 1'b1; req_n = n; req_a = a; req_r = r;
    run(ncyc);
  endtask

  task automatic bad_case(input int n, input int a, input int r, input string tag);
    pfd_on = 1'b0;
    load_run(n, a, r, 600);
    chk(cfg_err == 1'b1, {"R4 error flag ", tag}, int'(cfg_err), 1);
    fb_seen = 0; r_seen = 0;
    run(400);
    chk(fb_seen == 0, {"R4 feedback quiet ", tag}, fb_seen, 0);
    chk(r_seen == 0, {"R4 reference quiet ", tag}, r_seen, 0);
    chk(!pfd_up && !pfd_dn, {"R4 detector quiet ", tag}, {30'd0, pfd_up, pfd_dn}, 0);
    fb_skip = 1'b1; r_skip = 1'b1; fb_seen = 0;
    load_run(5, 2, 4, 1200);
    chk(cfg_err == 1'b0, {"R5 error cleared ", tag}, int'(cfg_err), 0);
    chk(fb_seen >= 3, {"R5 feedback resumes ", tag}, fb_seen, 3);
    pfd_on = 1'b1; pfd_sync = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // R7 reset state
    chk(fb_pulse == 0 && ref_pulse == 0, "R7 reset pulses", {30'd0, fb_pulse, ref_pulse}, 0);
    chk(pfd_up == 0 && pfd_dn == 0, "R7 reset detector", {30'd0, pfd_up, pfd_dn}, 0);
    chk(cfg_err == 0, "R7 reset error flag", int'(cfg_err), 0);
    rst = 1'b0;
    run(1500);
    chk(fb_seen >= 10, "R7 default ratio runs", fb_seen, 10);
    // directed corners: A=0, A=N, N=3, R=3
    load_run(3, 0, 3, 1200);
    load_run(3, 3, 3, 1200);
    ref_div = 4;
    load_run(6, 5, 9, 1200);
    // constrained random settings
    for (int k = 0; k < 6; k++) begin
      int n = 3 + ($urandom % 6);
      int a = $urandom % (n + 1);
      int r = 3 + ($urandom % 8);
      ref_div = 1 + ($urandom % 4);
      load_run(n, a, r, 1200);
    end
    ref_div = 2;
    bad_case(2, 0, 5, "N<3");
    bad_case(4, 5, 5, "A>N");
    bad_case(5, 1, 2, "R<3");
    load_run(7, 7, 3, 1200);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule